// File: doc/BRIEF.md
# Audio sample delay line

The block holds back a stream of 8-bit two's-complement audio samples by a delay chosen in whole milliseconds. Each sample that arrives with its strobe is written into a circular buffer at the position of a running write counter. The block then reads the buffer at the counter minus the delay expressed in sample periods, and presents that older sample with a one-cycle output strobe. Sample values pass through unchanged.

The buffer is a single-port synchronous RAM inside the block, so every accepted sample takes two clock cycles: a write step followed by a read step. The design expects a 1 MHz system clock with samples every 20 µs, which is 50 samples per millisecond. Storage depth is set by `ADDR_W` and the number of samples per millisecond by `SAMPLES_PER_MS`. The full-rate setting is `ADDR_W = 14` and `SAMPLES_PER_MS = 50`, which holds up to 255 ms of audio. The default parameters select a smaller buffer (4096 entries at 16 samples per millisecond). The delay offset `delay_ms_i × SAMPLES_PER_MS` is cut down to `ADDR_W` bits, and the subtraction wraps modulo the buffer depth.

Top module: `audio_delay_line`

## Requirements
- R1: While reset is asserted and after it is released, out_vld_o is 0 and out_sample_o is 0 until the first accepted sample produces an output.
- R2: Each accepted sample is written at the current write-counter address, and the counter then advances by exactly one, modulo 2^ADDR_W. With a delay of one millisecond, the output is therefore the sample stored SAMPLES_PER_MS positions back.
- R3: If in_vld_i is high in a cycle where the block is idle, out_vld_o is high in the second cycle after that one, and for that single cycle only.
- R4: The output sample equals the value last written at address (c − delay_ms_i × SAMPLES_PER_MS) mod 2^ADDR_W. Here c is the counter address that the current sample was written to, and delay_ms_i is taken in the read step.
- R5: With delay_ms_i = 0, the output sample equals the sample just accepted.
- R6: out_sample_o keeps its value in every cycle in which out_vld_o is low.
- R7: While in_vld_i is low, the block writes nothing, does not move the counter and produces no output strobe, whatever in_sample_i does.
- R8: in_vld_i is ignored in the read step that follows an accepted sample. A strobe two cycles long produces one write, one counter step and one output.
- R9: When delay_ms_i × SAMPLES_PER_MS reaches 2^ADDR_W or more, only its low ADDR_W bits set the offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_vld_i | input | 1 | Input sample strobe |
| in_sample_i | input | DATA_W | Input sample, two's complement |
| delay_ms_i | input | DELAY_W | Delay in milliseconds, unsigned |
| out_vld_o | output | 1 | Output sample strobe, one cycle |
| out_sample_o | output | DATA_W | Delayed sample, held between strobes |

## Verification
The bench first fills every buffer location at zero delay and then sweeps every delay value. It uses a small buffer and a samples-per-millisecond factor of three, so large delays drive the offset past the buffer depth. A design that did not truncate the offset, or that took the wrong sign in the subtraction, would return samples from the wrong age. A design with a one-off error in the read address would fail the zero-delay and one-millisecond reads, since those expect the current sample and the one SAMPLES_PER_MS positions back. The bench also holds the strobe through the read step and toggles the data with the strobe low. A controller that re-armed too early would write twice and step the counter twice. A controller that ignored the strobe level would corrupt locations that later reads expose.

// File: rtl/audio_dly_pkg.sv
package audio_dly_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_READ = 1'b1
  } dly_state_e;

  typedef struct packed {
    logic addr_sel;  // 1: read address, 0: write counter
    logic mem_en;
    logic mem_wr;
    logic count_en;
    logic out_en;
  } dly_ctrl_t;

endpackage

// File: rtl/audio_dly_ctrl.sv
module audio_dly_ctrl
  import audio_dly_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      in_vld_i,
  output dly_ctrl_t ctrl_o
);

  dly_state_e state_q, state_d;

  always_comb begin
    ctrl_o  = '0;
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (in_vld_i) begin
          ctrl_o.mem_en = 1'b1;
          ctrl_o.mem_wr = 1'b1;
          state_d       = ST_READ;
        end
      end
      ST_READ: begin
        ctrl_o.addr_sel = 1'b1;
        ctrl_o.mem_en   = 1'b1;
        ctrl_o.count_en = 1'b1;
        ctrl_o.out_en   = 1'b1;
        state_d         = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  AST_WR_THEN_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o.mem_wr |=> (ctrl_o.out_en && !ctrl_o.mem_wr)); // R3
  AST_NO_BACK_TO_BACK_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o.out_en |=> !ctrl_o.out_en); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_vld_i && !ctrl_o.out_en) |-> !ctrl_o.mem_en); // R7

endmodule

// File: rtl/audio_dly_addr.sv
module audio_dly_addr #(
  parameter int ADDR_W         = 12,
  parameter int DELAY_W        = 8,
  parameter int SAMPLES_PER_MS = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               count_en_i,
  input  logic               addr_sel_i,
  input  logic [DELAY_W-1:0] delay_ms_i,
  output logic [ADDR_W-1:0]  addr_o
);

  logic [ADDR_W-1:0] wr_ptr_q;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] rd_addr;

  // Offset truncated to the buffer depth; subtraction wraps modulo 2^ADDR_W.
  assign offset  = ADDR_W'(32'(delay_ms_i) * 32'(SAMPLES_PER_MS));
  assign rd_addr = wr_ptr_q - offset;
  assign addr_o  = addr_sel_i ? rd_addr : wr_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         wr_ptr_q <= '0;
    else if (count_en_i) wr_ptr_q <= wr_ptr_q + 1'b1;
  end

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_en_i |=> (wr_ptr_q == ADDR_W'($past(wr_ptr_q) + 1'b1))); // R2
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !count_en_i |=> $stable(wr_ptr_q)); // R7

endmodule

// File: rtl/audio_dly_ram.sv
module audio_dly_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i && wr_i) mem_q[addr_i] <= wdata_i;
  end

  // Read port updates only on reads, so it also serves as the output hold register.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_o <= '0;
    else if (en_i && !wr_i)  rdata_o <= mem_q[addr_i];
  end

endmodule

// File: rtl/audio_delay_line.sv
module audio_delay_line
  import audio_dly_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int DELAY_W        = 8,
  parameter int ADDR_W         = 12,
  parameter int SAMPLES_PER_MS = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_vld_i,
  input  logic [DATA_W-1:0]  in_sample_i,
  input  logic [DELAY_W-1:0] delay_ms_i,
  output logic               out_vld_o,
  output logic [DATA_W-1:0]  out_sample_o
);

  dly_ctrl_t         ctrl;
  logic [ADDR_W-1:0] mem_addr;

  audio_dly_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_vld_i (in_vld_i),
    .ctrl_o   (ctrl)
  );

  audio_dly_addr #(
    .ADDR_W         (ADDR_W),
    .DELAY_W        (DELAY_W),
    .SAMPLES_PER_MS (SAMPLES_PER_MS)
  ) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .count_en_i (ctrl.count_en),
    .addr_sel_i (ctrl.addr_sel),
    .delay_ms_i (delay_ms_i),
    .addr_o     (mem_addr)
  );

  audio_dly_ram #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl.mem_en),
    .wr_i    (ctrl.mem_wr),
    .addr_i  (mem_addr),
    .wdata_i (in_sample_i),
    .rdata_o (out_sample_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_vld_o <= 1'b0;
    else         out_vld_o <= ctrl.out_en;
  end

  AST_OUT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |=> !out_vld_o); // R3
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_vld_o |-> $stable(out_sample_o)); // R6
  AST_OUT_NEEDS_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_vld_o) |-> !$past(in_vld_i, 1) || $past(ctrl.addr_sel, 1)); // R7

endmodule

// File: tb/audio_delay_line_tb_top.sv
module audio_delay_line_tb_top;

  localparam int AW    = 8;
  localparam int SPMS  = 3;
  localparam int DEPTH = 1 << AW;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_vld = 1'b0;
  logic [7:0] in_smp = 8'h00;
  logic [7:0] dly = 8'h00;
  logic       out_vld;
  logic [7:0] out_smp;

  int         n_cmp = 0;
  int         n_bad = 0;
  int         cnt = 0;
  int         seq = 0;
  logic [7:0] mdl [DEPTH];
  bit         done = 1'b0;

  always #4 clk_i = ~clk_i;

  audio_delay_line #(
    .DATA_W (8), .DELAY_W (8), .ADDR_W (AW), .SAMPLES_PER_MS (SPMS)
  ) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_vld_i     (in_vld),
    .in_sample_i  (in_smp),
    .delay_ms_i   (dly),
    .out_vld_o    (out_vld),
    .out_sample_o (out_smp)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One accepted sample; hold2 keeps the strobe high through the read step.
  task automatic send(input logic [7:0] s, input bit hold2, input string req);
    int exp;
    @(negedge clk_i);
    in_vld = 1'b1;
    in_smp = s;
    mdl[cnt] = s;
    exp = int'(mdl[(cnt - int'(dly) * SPMS) & (DEPTH - 1)]);
    cnt = (cnt + 1) % DEPTH;
    @(negedge clk_i);
    if (!hold2) begin
      in_vld = 1'b0;
      in_smp = ~s;
    end
    @(negedge clk_i);
    in_vld = 1'b0;
    chk({req, " R3 out_vld"}, int'(out_vld), 1);
    chk({req, " sample"}, int'(out_smp), exp);
    @(negedge clk_i);
    chk("R3 pulse width", int'(out_vld), 0);
    chk("R6 hold", int'(out_smp), exp);
    repeat (16) @(negedge clk_i);
    chk("R6 hold late", int'(out_smp), exp);
  endtask

  function automatic logic [7:0] pat();
    seq++;
    return 8'((seq * 37 + 11) ^ (seq >> 3));
  endfunction

  function automatic string tag(input int d);
    if (d == 0)                  return "R5";
    else if (d == 1)             return "R2";
    else if (d * SPMS >= DEPTH)  return "R9";
    else                         return "R4";
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk_i);
    chk("R1 vld in reset", int'(out_vld), 0);
    chk("R1 sample in reset", int'(out_smp), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R1 vld after reset", int'(out_vld), 0);
    chk("R1 sample after reset", int'(out_smp), 0);

    // Fill every location at zero delay.
    dly = 8'd0;
    for (int i = 0; i < DEPTH; i++) send(pat(), 1'b0, "R5");

    // Strobe low with moving data: nothing may happen.
    begin
      logic [7:0] held;
      held = out_smp;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk_i);
        in_smp = 8'(i * 13 + 7);
        chk("R7 no strobe", int'(out_vld), 0);
        chk("R7 sample untouched", int'(out_smp), int'(held));
      end
    end

    // Every delay value, two samples each.
    for (int d = 0; d < 256; d++) begin
      dly = 8'(d);
      send(pat(), 1'b0, tag(d));
      send(pat(), 1'b0, tag(d));
    end

    // Long strobe: one write, one step, one output.
    dly = 8'd0;
    send(8'hA5, 1'b1, "R8");
    chk("R8 no extra out", int'(out_vld), 0);
    dly = 8'd1;
    send(8'h3C, 1'b0, "R8");
    dly = 8'd0;
    send(8'h81, 1'b0, "R8");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule